// File: doc/BRIEF.md
# Maskable Interrupt Flag Controller

This block gathers interrupt requests from up to sixteen peripheral sources. Each request is caught in its own bit of a 16-bit flag word. From the pending flags it picks one winner and presents it to the processor core as three registered outputs: a request line, a 3-bit interrupt level and a vector number. The winner is a flag that is set, whose source is enabled, and that has the highest level of those pending.

Software programs the block through a small synchronous register port. The port holds a master enable, a per-source enable word, a trigger-mode word for the first eight sources and four words of 3-bit levels. It can also read the flag word, and it clears edge-mode flags by writing ones to it.

A source in edge mode latches its flag on a rising request, and the flag holds until software clears it. A source in level mode ignores those writes and simply mirrors its request line. A flag that is still set keeps the request asserted, so the same interrupt comes back once the core permits interrupts again.

Top module: `mifc_top`

## Requirements
- R1: After reset, every register reads 0, all flags are 0, and `irq_o`, `irq_level_o` and `irq_vector_o` are 0.
- R2: Bit 0 of register 0 is the master enable. While it is 0, `irq_o` is 0 one cycle later, whatever the flags, enables and levels hold.
- R3: A source in edge mode sets its flag one clock after its request is first sampled high (a rising edge, the first sample after reset included). The flag stays at 1 after the request drops.
- R4: Writing register 1 with bit n = 1 clears edge-mode flag n at that clock edge. A 0 bit leaves the flag unchanged. If a new rising edge arrives in the same cycle as the clear, the set wins.
- R5: Register 3 bits 0..7 select level mode (1) for sources 0..7. A level-mode flag equals the request sampled at the previous edge, and writing 1 to it in register 1 has no effect.
- R6: Flag positions 5 and 6 always read 0 and cannot be set. Register 3 bits 8..15 read 0.
- R7: While `irq_o` is 1, `irq_vector_o` equals the winning flag's bit position plus 4.
- R8: Register 2 holds one enable bit per source and reads back as written. A flag takes part in arbitration only when its enable bit is 1.
- R9: Registers 4..7 hold the levels of sources 4k..4k+3, with source 4k+j in bits [4j+2:4j] and the other bits reading 0. The winner is the pending source with the highest level. On equal levels, the lowest bit position wins. `irq_level_o` carries the winner's level.
- R10: `irq_o`, `irq_level_o` and `irq_vector_o` are registered and follow the flags, enables, levels and master enable of the previous cycle. When nothing is pending, all three are 0.
- R11: A pending flag that is not cleared keeps `irq_o` asserted on every following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | 16 | Synchronous request lines from the peripherals, one per source |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register select |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request to the core |
| irq_level_o | output | 3 | Level of the request |
| irq_vector_o | output | 5 | Vector number of the request |

## Verification
Each result has its own latency:
- A register write takes effect at the clock edge that samples it, and reads back on the following read.
- A request sampled at one edge appears in the flag word right after that edge.
- The core-side outputs reflect that flag one edge later. Two edges therefore separate a source change from the matching change at `irq_o`.

The bench drives stimulus just after a falling edge. It keeps a cycle-accurate model that advances on the same rising edge as the design. It compares the outputs, and the read data for the selected register, at the next falling edge. The directed cases count these edges explicitly before they check values against their own expectations.

// File: rtl/mifc_pkg.sv
package mifc_pkg;
    localparam int NSRC_DEF     = 16;
    localparam int LVL_SRCS_DEF = 8;
    localparam int LVL_W_DEF    = 3;
    localparam int VEC_W_DEF    = 5;
    localparam int VEC_OFS_DEF  = 4;
    localparam int DATA_W_DEF   = 16;
    localparam int ADDR_W_DEF   = 3;
    localparam logic [15:0] VALID_DEF = 16'hFF9F;
    localparam int FIELD_STRIDE = 4;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_FLAG = 3'd1,
        REG_EN   = 3'd2,
        REG_MODE = 3'd3,
        REG_LVL  = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/mifc_cfg_regs.sv
module mifc_cfg_regs
    import mifc_pkg::*;
#(
    parameter int NSRC     = NSRC_DEF,
    parameter int LVL_SRCS = LVL_SRCS_DEF,
    parameter int LVL_W    = LVL_W_DEF,
    parameter int DATA_W   = DATA_W_DEF,
    parameter int ADDR_W   = ADDR_W_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [NSRC-1:0]        flags,
    output logic                   gen_en,
    output logic [NSRC-1:0]        src_en,
    output logic [LVL_SRCS-1:0]    mode_lvl,
    output logic [NSRC*LVL_W-1:0]  lvl_flat,
    output logic [DATA_W-1:0]      rdata
);
    localparam int LPW       = DATA_W / FIELD_STRIDE;
    localparam int LVL_WORDS = NSRC / LPW;

    typedef struct packed {
        logic                  gen;
        logic [NSRC-1:0]       en;
        logic [LVL_SRCS-1:0]   mode;
        logic [NSRC*LVL_W-1:0] lvl;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (addr == ADDR_W'(REG_CTRL)) cfg_d.gen  = wdata[0];
            if (addr == ADDR_W'(REG_EN))   cfg_d.en   = wdata[NSRC-1:0];
            if (addr == ADDR_W'(REG_MODE)) cfg_d.mode = wdata[LVL_SRCS-1:0];
            for (int k = 0; k < LVL_WORDS; k++) begin
                if (addr == ADDR_W'(int'(REG_LVL) + k)) begin
                    for (int j = 0; j < LPW; j++) begin
                        cfg_d.lvl[(k*LPW+j)*LVL_W +: LVL_W] = wdata[j*FIELD_STRIDE +: LVL_W];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(REG_CTRL)) rdata[0] = cfg_q.gen;
        if (addr == ADDR_W'(REG_FLAG)) rdata[NSRC-1:0] = flags;
        if (addr == ADDR_W'(REG_EN))   rdata[NSRC-1:0] = cfg_q.en;
        if (addr == ADDR_W'(REG_MODE)) rdata[LVL_SRCS-1:0] = cfg_q.mode;
        for (int k = 0; k < LVL_WORDS; k++) begin
            if (addr == ADDR_W'(int'(REG_LVL) + k)) begin
                for (int j = 0; j < LPW; j++) begin
                    rdata[j*FIELD_STRIDE +: LVL_W] = cfg_q.lvl[(k*LPW+j)*LVL_W +: LVL_W];
                end
            end
        end
    end

    assign gen_en   = cfg_q.gen;
    assign src_en   = cfg_q.en;
    assign mode_lvl = cfg_q.mode;
    assign lvl_flat = cfg_q.lvl;

    assert_en_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(REG_EN)) |=> (src_en == $past(wdata[NSRC-1:0])));
endmodule

// File: rtl/mifc_flag_bank.sv
module mifc_flag_bank
    import mifc_pkg::*;
#(
    parameter int               NSRC     = NSRC_DEF,
    parameter int               LVL_SRCS = LVL_SRCS_DEF,
    parameter logic [NSRC-1:0]  VALID    = VALID_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     src_req,
    input  logic [LVL_SRCS-1:0] mode_lvl,
    input  logic                clr_we,
    input  logic [NSRC-1:0]     clr_mask,
    output logic [NSRC-1:0]     flags
);
    typedef struct packed {
        logic [NSRC-1:0] flag;
        logic [NSRC-1:0] prev;
    } fb_t;

    fb_t fb_d, fb_q;
    logic [NSRC-1:0] mode_ext;

    assign mode_ext = NSRC'(mode_lvl);

    always_comb begin
        fb_d.prev = src_req & VALID;
        for (int i = 0; i < NSRC; i++) begin
            if (!VALID[i]) begin
                fb_d.flag[i] = 1'b0;
            end else if (mode_ext[i]) begin
                fb_d.flag[i] = src_req[i];
            end else begin
                fb_d.flag[i] = (fb_q.flag[i] & ~(clr_we & clr_mask[i]))
                             | (src_req[i] & ~fb_q.prev[i]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fb_q <= '0;
        else        fb_q <= fb_d;
    end

    assign flags = fb_q.flag;

    assert_unused_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~VALID) == '0);

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        if (VALID[g]) begin : g_valid
            assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (flags[g] && !mode_ext[g] && !(clr_we && clr_mask[g])) |=> flags[g]);
            assert_level_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
                mode_ext[g] |=> (flags[g] == $past(src_req[g])));
        end
    end
endmodule

// File: rtl/mifc_arbiter.sv
module mifc_arbiter
    import mifc_pkg::*;
#(
    parameter int NSRC    = NSRC_DEF,
    parameter int LVL_W   = LVL_W_DEF,
    parameter int VEC_W   = VEC_W_DEF,
    parameter int VEC_OFS = VEC_OFS_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  gen_en,
    input  logic [NSRC-1:0]       flags,
    input  logic [NSRC-1:0]       src_en,
    input  logic [NSRC*LVL_W-1:0] lvl_flat,
    output logic                  irq,
    output logic [LVL_W-1:0]      irq_level,
    output logic [VEC_W-1:0]      irq_vec
);
    localparam int VEC_MAX = NSRC - 1 + VEC_OFS;

    typedef struct packed {
        logic             req;
        logic [LVL_W-1:0] lvl;
        logic [VEC_W-1:0] vec;
    } arb_t;

    arb_t arb_d, arb_q;
    logic [NSRC-1:0] pend;
    logic             found;
    logic [LVL_W-1:0] best_lvl;
    logic [VEC_W-1:0] best_vec;

    assign pend = flags & src_en;

    always_comb begin
        found    = 1'b0;
        best_lvl = '0;
        best_vec = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && (!found || lvl_flat[i*LVL_W +: LVL_W] > best_lvl)) begin
                found    = 1'b1;
                best_lvl = lvl_flat[i*LVL_W +: LVL_W];
                best_vec = VEC_W'(i + VEC_OFS);
            end
        end
        arb_d.req = found && gen_en;
        arb_d.lvl = arb_d.req ? best_lvl : '0;
        arb_d.vec = arb_d.req ? best_vec : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

    assign irq       = arb_q.req;
    assign irq_level = arb_q.lvl;
    assign irq_vec   = arb_q.vec;

    assert_gate_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> !irq);
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (irq_level == '0 && irq_vec == '0));
    assert_none_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> !irq);
    assert_vec_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_vec >= VEC_W'(VEC_OFS) && irq_vec <= VEC_W'(VEC_MAX)));
    assert_recur_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && (pend != '0)) |=> irq);
endmodule

// File: rtl/mifc_top.sv
module mifc_top
    import mifc_pkg::*;
#(
    parameter int              NSRC     = NSRC_DEF,
    parameter int              LVL_SRCS = LVL_SRCS_DEF,
    parameter int              LVL_W    = LVL_W_DEF,
    parameter int              VEC_W    = VEC_W_DEF,
    parameter int              VEC_OFS  = VEC_OFS_DEF,
    parameter int              DATA_W   = DATA_W_DEF,
    parameter int              ADDR_W   = ADDR_W_DEF,
    parameter logic [NSRC-1:0] VALID    = VALID_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_req_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic [LVL_W-1:0]  irq_level_o,
    output logic [VEC_W-1:0]  irq_vector_o
);
    logic                  gen_en;
    logic [NSRC-1:0]       src_en;
    logic [LVL_SRCS-1:0]   mode_lvl;
    logic [NSRC*LVL_W-1:0] lvl_flat;
    logic [NSRC-1:0]       flags;
    logic                  clr_we;

    assign clr_we = bus_we_i && (bus_addr_i == ADDR_W'(REG_FLAG));

    mifc_cfg_regs #(
        .NSRC(NSRC), .LVL_SRCS(LVL_SRCS), .LVL_W(LVL_W),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we_i), .addr(bus_addr_i),
        .wdata(bus_wdata_i), .flags(flags), .gen_en(gen_en), .src_en(src_en),
        .mode_lvl(mode_lvl), .lvl_flat(lvl_flat), .rdata(bus_rdata_o)
    );

    mifc_flag_bank #(
        .NSRC(NSRC), .LVL_SRCS(LVL_SRCS), .VALID(VALID)
    ) u_flags (
        .clk(clk), .rst_n(rst_n), .src_req(src_req_i), .mode_lvl(mode_lvl),
        .clr_we(clr_we), .clr_mask(bus_wdata_i[NSRC-1:0]), .flags(flags)
    );

    mifc_arbiter #(
        .NSRC(NSRC), .LVL_W(LVL_W), .VEC_W(VEC_W), .VEC_OFS(VEC_OFS)
    ) u_arb (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .flags(flags),
        .src_en(src_en), .lvl_flat(lvl_flat), .irq(irq_o),
        .irq_level(irq_level_o), .irq_vec(irq_vector_o)
    );
endmodule

// File: tb/tb_mifc_top.sv
`timescale 1ns/1ps
module tb_mifc_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] VMASK = 16'hFF9F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src = '0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    logic [2:0]  lvl;
    logic [4:0]  vec;

    int n_chk = 0;
    int n_fail = 0;
    bit mon = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mifc_top dut (
        .clk(clk), .rst_n(rst_n), .src_req_i(src), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .irq_level_o(lvl), .irq_vector_o(vec)
    );

    // reference model
    logic [15:0] m_flag, m_prev, m_en;
    logic [7:0]  m_mode;
    logic        m_gen;
    logic [2:0]  m_lvl [16];
    logic        m_irq;
    logic [2:0]  m_level;
    logic [4:0]  m_vec;

    function automatic logic [15:0] next_flags();
        logic [15:0] r;
        for (int i = 0; i < 16; i++) begin
            if (!VMASK[i]) r[i] = 1'b0;
            else if (i < 8 && m_mode[i]) r[i] = src[i];
            else r[i] = (src[i] && !m_prev[i]) ||
                        (m_flag[i] && !(we && addr == 3'd1 && wdata[i]));
        end
        return r;
    endfunction

    function automatic logic [8:0] pick();
        logic       hit = 1'b0;
        logic [2:0] bl = '0;
        logic [4:0] bv = '0;
        for (int i = 15; i >= 0; i--) begin
            if (m_flag[i] && m_en[i] && (!hit || m_lvl[i] >= bl)) begin
                hit = 1'b1; bl = m_lvl[i]; bv = 5'(i + 4);
            end
        end
        if (!(hit && m_gen)) return '0;
        return {1'b1, bl, bv};
    endfunction

    function automatic logic [15:0] model_read(input logic [2:0] a);
        logic [15:0] r = '0;
        case (a)
            3'd0: r[0] = m_gen;
            3'd1: r = m_flag;
            3'd2: r = m_en;
            3'd3: r[7:0] = m_mode;
            default: for (int j = 0; j < 4; j++) r[j*4 +: 3] = m_lvl[(a-4)*4 + j];
        endcase
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flag <= '0; m_prev <= '0; m_en <= '0; m_mode <= '0; m_gen <= 1'b0;
            for (int i = 0; i < 16; i++) m_lvl[i] <= '0;
            m_irq <= 1'b0; m_level <= '0; m_vec <= '0;
        end else begin
            logic [8:0] p;
            p = pick();
            m_irq <= p[8]; m_level <= p[7:5]; m_vec <= p[4:0];
            m_flag <= next_flags();
            m_prev <= src;
            if (we) begin
                case (addr)
                    3'd0: m_gen <= wdata[0];
                    3'd1: ;
                    3'd2: m_en <= wdata;
                    3'd3: m_mode <= wdata[7:0];
                    default: for (int j = 0; j < 4; j++) m_lvl[(addr-4)*4 + j] <= wdata[j*4 +: 3];
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model (R10 outputs, register reads)
    always @(negedge clk) begin
        if (rst_n && mon) begin
            chk("R10 irq", {31'b0, irq}, {31'b0, m_irq});
            chk("R9 level", {29'b0, lvl}, {29'b0, m_level});
            chk("R7 vector", {27'b0, vec}, {27'b0, m_vec});
            chk(addr == 3'd1 ? "R3 flag read" : "R8 reg read", {16'b0, rdata},
                {16'b0, model_read(addr)});
        end
    end

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        we = 1'b1; addr = a; wdata = d;
        cyc();
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [15:0] exp);
        addr = a;
        #1;
        chk(tag, {16'b0, rdata}, {16'b0, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        cyc(3);
        rst_n = 1'b1;
        cyc();
        // R1: reset values
        for (int a = 0; a < 8; a++) rd_chk("R1 reset reg", 3'(a), 16'h0000);
        chk("R1 reset irq", {29'b0, irq, lvl[0], vec[0]}, 32'd0);
        mon = 1'b1;

        // R2: master enable gate
        wr(3'd2, 16'hFFFF);
        src[0] = 1'b1; cyc(); src[0] = 1'b0;
        cyc(2);
        chk("R2 gate off", {31'b0, irq}, 32'd0);
        rd_chk("R3 flag held", 3'd1, 16'h0001);
        wr(3'd0, 16'h0001);
        chk("R10 one cycle later", {31'b0, irq}, 32'd0);
        cyc();
        chk("R2 gate on", {31'b0, irq}, 32'd1);
        chk("R7 vector of bit 0", {27'b0, vec}, 32'd4);
        cyc(3);
        chk("R11 recurs", {31'b0, irq}, 32'd1);

        // R4: write 0 keeps, write 1 clears
        wr(3'd1, 16'h0000);
        rd_chk("R4 write 0 no effect", 3'd1, 16'h0001);
        wr(3'd1, 16'h0001);
        rd_chk("R4 write 1 clears", 3'd1, 16'h0000);
        cyc();
        chk("R10 drop", {31'b0, irq}, 32'd0);

        // R6: unused positions
        src = 16'h0060; cyc(); src = '0; cyc();
        rd_chk("R6 unused flags", 3'd1, 16'h0000);
        wr(3'd3, 16'hFFFF);
        rd_chk("R6 mode upper bits", 3'd3, 16'h00FF);
        wr(3'd3, 16'h0004);

        // R5: level mode on source 2
        src[2] = 1'b1; cyc();
        rd_chk("R5 level set", 3'd1, 16'h0004);
        wr(3'd1, 16'h0004);
        rd_chk("R5 clear ignored", 3'd1, 16'h0004);
        src[2] = 1'b0; cyc();
        rd_chk("R5 follows source", 3'd1, 16'h0000);
        wr(3'd3, 16'h0000);

        // R9: priority and ties
        wr(3'd4, 16'h5000);
        wr(3'd6, 16'h0050);
        wr(3'd7, 16'h0002);
        rd_chk("R9 level readback", 3'd6, 16'h0050);
        src = 16'h1208; cyc(); src = '0; cyc();
        chk("R9 tie lowest", {27'b0, vec}, 32'd7);
        chk("R9 level out", {29'b0, lvl}, 32'd5);
        wr(3'd1, 16'h0008); cyc();
        chk("R9 next winner", {27'b0, vec}, 32'd13);
        // R8: per-source enable
        wr(3'd2, 16'hFDFF); cyc();
        chk("R8 disabled source skipped", {27'b0, vec}, 32'd16);
        chk("R8 low level", {29'b0, lvl}, 32'd2);
        // R4: set wins over same-cycle clear
        wr(3'd1, 16'hFFFF); src[0] = 1'b1; wr(3'd1, 16'h0001); src[0] = 1'b0;
        rd_chk("R4 set wins", 3'd1, 16'h0001);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            src = 16'($urandom & $urandom & $urandom);
            we = ($urandom % 4) == 0;
            addr = 3'($urandom % 8);
            wdata = 16'($urandom);
            if (addr == 3'd0 && ($urandom % 8) != 0) wdata[0] = 1'b1;
            if (addr == 3'd1) wdata = wdata & 16'($urandom);
            cyc();
        end
        we = 1'b0;
        cyc(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule